// File: doc/BRIEF.md
# Programmable Input Pin Toggle Generator

This block makes one chosen bit of an 8-bit input port toggle as a square wave. The time spent high and the time spent low are programmed separately, both in bus cycles. A repeat budget limits how many transitions are made before the generator stops by itself. Every transition inverts only the selected bit. The other bits are taken from the current port byte, and the merged byte goes to a downstream port-update path as a one-cycle strobe.

Software-side logic drives a load pulse along with the high time, the low time, the repeat budget and a bit index. A clear pulse stops the generator. A synchronous reset cancels any pending transition and returns the stored bit to 0. Status outputs show whether the generator is running, the current bit level and the cycles left until the next transition.

Top module: `tgl_gen`

## Requirements
- R1: At each expiry the stored bit is inverted and `upd_valid` is high for exactly one cycle, with `upd_data` carrying the new bit value at the position of the selected bit.
- R2: In a strobed byte, every bit other than the selected one equals the `port_in` value sampled at the clock edge where the transition happens.
- R3: After a transition to 1 the next strobe comes `cfg_on` cycles later. After a transition to 0 it comes `cfg_off` cycles later.
- R4: A programmed on or off time of 0 behaves as 1 cycle.
- R5: With a repeat budget of N, the generator makes N+1 transitions after a load and then goes idle (`active` low, `remain` 0).
- R6: A load cancels any pending transition. The first strobe after it comes `cfg_on` cycles after the load edge if `bit_val` is 1, or `cfg_off` cycles after it if `bit_val` is 0.
- R7: A clear cancels the pending transition and empties the repeat budget. No further strobe follows, `active` and `remain` are 0, and `bit_val` is unchanged. Clear takes priority over a load in the same cycle.
- R8: Reset forces `active`, `bit_val`, `remain` and `upd_valid` to 0. Any pending transition is cancelled.
- R9: `remain` equals the interval just after a load or a reload and then falls by 1 each cycle. The strobe appears in the cycle after `remain` was 1.
- R10: `cfg_sel` (bit index 0 to 7) picks the toggled bit. The index is captured on load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load configuration and start |
| cfg_clear | input | 1 | Cancel and empty repeat budget |
| cfg_sel | input | 3 | Index of toggled bit |
| cfg_on | input | 16 | High time in cycles |
| cfg_off | input | 16 | Low time in cycles |
| cfg_rep | input | 16 | Repeat budget (transitions minus one) |
| port_in | input | 8 | Current port byte |
| upd_valid | output | 1 | One-cycle update strobe |
| upd_data | output | 8 | Merged port byte |
| active | output | 1 | Generator running |
| bit_val | output | 1 | Current toggled bit level |
| remain | output | 16 | Cycles left to next transition |

## Verification
The assertions assume that `cfg_sel` is held only at load time and that `port_in` is a clean registered value at each edge. The merge check compares against the previous-cycle `port_in`. The bench follows these assumptions by changing all inputs on the falling edge and by driving `cfg_load` and `cfg_clear` as single-cycle pulses. Scenarios that restart or clear a running generator place their pulse between strobes, so each strobe comes from exactly one configuration.

// File: rtl/tgl_pkg.sv
package tgl_pkg;
  localparam int unsigned TGL_PORT_W   = 8;
  localparam int unsigned TGL_CNT_W    = 16;
  localparam int unsigned TGL_REP_W    = 16;
  localparam int unsigned TGL_MIN_IVAL = 1;
endpackage

// File: rtl/tgl_cfg.sv
module tgl_cfg #(
  parameter int unsigned PORT_W = tgl_pkg::TGL_PORT_W,
  parameter int unsigned CNT_W  = tgl_pkg::TGL_CNT_W,
  localparam int unsigned SEL_W = $clog2(PORT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [SEL_W-1:0]  sel,
  input  logic [CNT_W-1:0]  on_in,
  input  logic [CNT_W-1:0]  off_in,
  output logic [CNT_W-1:0]  on_c,
  output logic [CNT_W-1:0]  off_c,
  output logic [CNT_W-1:0]  on_q,
  output logic [CNT_W-1:0]  off_q,
  output logic [PORT_W-1:0] mask_q
);
  localparam logic [CNT_W-1:0] MIN_IV = CNT_W'(tgl_pkg::TGL_MIN_IVAL);

  logic [PORT_W-1:0] mask_c;

  assign on_c  = (on_in  < MIN_IV) ? MIN_IV : on_in;
  assign off_c = (off_in < MIN_IV) ? MIN_IV : off_in;

  for (genvar i = 0; i < PORT_W; i++) begin : g_dec
    assign mask_c[i] = (sel == SEL_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q   <= MIN_IV;
      off_q  <= MIN_IV;
      mask_q <= PORT_W'(1);
    end else if (load) begin
      on_q   <= on_c;
      off_q  <= off_c;
      mask_q <= mask_c;
    end
  end

  assert_min_on_R4: assert property (@(posedge clk) disable iff (rst)
    load |=> (on_q != '0) && (off_q != '0));
  assert_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    load |=> $onehot0(mask_q) && (mask_q != '0));
endmodule

// File: rtl/tgl_timer.sv
module tgl_timer #(
  parameter int unsigned CNT_W = tgl_pkg::TGL_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic [CNT_W-1:0] val,
  output logic             expire,
  output logic             run,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign expire = run && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst || stop) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= val;
    end else if (run) begin
      if (cnt == ONE) begin
        run <= 1'b0;
        cnt <= '0;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

  assert_run_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt != '0));
  assert_countdown_R9: assert property (@(posedge clk) disable iff (rst)
    (run && !start && !stop && cnt > ONE) |=> (cnt == $past(cnt) - ONE) && run);
  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
    !run |-> (cnt == '0));
endmodule

// File: rtl/tgl_gen.sv
module tgl_gen #(
  parameter int unsigned PORT_W = tgl_pkg::TGL_PORT_W,
  parameter int unsigned CNT_W  = tgl_pkg::TGL_CNT_W,
  parameter int unsigned REP_W  = tgl_pkg::TGL_REP_W,
  localparam int unsigned SEL_W = $clog2(PORT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic              cfg_clear,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [CNT_W-1:0]  cfg_on,
  input  logic [CNT_W-1:0]  cfg_off,
  input  logic [REP_W-1:0]  cfg_rep,
  input  logic [PORT_W-1:0] port_in,
  output logic              upd_valid,
  output logic [PORT_W-1:0] upd_data,
  output logic              active,
  output logic              bit_val,
  output logic [CNT_W-1:0]  remain
);
  logic [CNT_W-1:0]  on_c, off_c, on_q, off_q, iv;
  logic [PORT_W-1:0] mask_q;
  logic [REP_W-1:0]  rep_q;
  logic              bit_q, expire, fire, more, load_ok, start;

  tgl_cfg #(.PORT_W(PORT_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst), .load(load_ok), .sel(cfg_sel),
    .on_in(cfg_on), .off_in(cfg_off),
    .on_c(on_c), .off_c(off_c), .on_q(on_q), .off_q(off_q), .mask_q(mask_q)
  );

  assign load_ok = cfg_load && !cfg_clear;
  assign fire    = expire && !cfg_load && !cfg_clear;
  assign more    = (rep_q != '0);
  assign start   = load_ok || (fire && more);
  // Load times the first interval from the current level; a reload from the new one.
  assign iv = load_ok ? (bit_q ? on_c : off_c) : (!bit_q ? on_q : off_q);

  tgl_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .start(start), .stop(cfg_clear), .val(iv),
    .expire(expire), .run(active), .cnt(remain)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q     <= 1'b0;
      rep_q     <= '0;
      upd_valid <= 1'b0;
      upd_data  <= '0;
    end else begin
      upd_valid <= fire;
      if (cfg_clear)          rep_q <= '0;
      else if (cfg_load)      rep_q <= cfg_rep;
      else if (fire && more)  rep_q <= rep_q - REP_W'(1);
      if (fire) begin
        bit_q    <= !bit_q;
        upd_data <= (port_in & ~mask_q) | (bit_q ? '0 : mask_q);
      end
    end
  end

  assign bit_val = bit_q;

  assert_toggle_R1: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> (bit_q != $past(bit_q)));
  assert_single_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> !upd_valid || $past(active));
  assert_merge_R2: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> (((upd_data ^ $past(port_in)) & ~mask_q) == '0));
  assert_bit_lane_R10: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> (((upd_data & mask_q) != '0) == bit_q));
  assert_strobe_needs_run_R5: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> $past(active));
  assert_clear_idles_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_clear |=> !active && !upd_valid && (remain == '0) && $stable(bit_q));
  assert_reset_state_R8: assert property (@(posedge clk)
    $past(rst) |-> !active && !bit_q && !upd_valid);
endmodule

// File: tb/sim_tgl_gen.sv
module sim_tgl_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_load = 1'b0, cfg_clear = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [15:0] cfg_on = '0, cfg_off = '0, cfg_rep = '0;
  logic [7:0] port_in = '0;
  logic upd_valid, active, bit_val;
  logic [7:0] upd_data;
  logic [15:0] remain;

  int n_chk = 0, n_fail = 0, cyc = 0, t0 = 0, ns = 0;
  int st_cyc [0:31];
  logic [7:0] st_dat [0:31];

  tgl_gen u0 (.clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_clear(cfg_clear),
    .cfg_sel(cfg_sel), .cfg_on(cfg_on), .cfg_off(cfg_off), .cfg_rep(cfg_rep),
    .port_in(port_in), .upd_valid(upd_valid), .upd_data(upd_data),
    .active(active), .bit_val(bit_val), .remain(remain));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(input int on, input int off, input int rep, input int sel);
    cfg_on = 16'(on); cfg_off = 16'(off); cfg_rep = 16'(rep); cfg_sel = 3'(sel);
    cfg_load = 1'b1;
    @(negedge clk);
    t0 = cyc;
    cfg_load = 1'b0;
    ns = 0;
  endtask

  task automatic collect(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (upd_valid && ns < 32) begin
        st_cyc[ns] = cyc - t0;
        st_dat[ns] = upd_data;
        ns++;
      end
    end
  endtask

  task automatic t_reset();
    chk(!active, "R8 active", int'(active), 0);
    chk(!bit_val, "R8 bit_val", int'(bit_val), 0);
    chk(remain == 0, "R8 remain", int'(remain), 0);
    chk(!upd_valid, "R8 upd_valid", int'(upd_valid), 0);
  endtask

  task automatic t_basic();
    port_in = 8'hA1;
    do_load(3, 5, 3, 2);
    chk(active, "R9 active after load", int'(active), 1);
    chk(remain == 5, "R6 first interval from low level", int'(remain), 5);
    collect(30);
    chk(ns == 4, "R5 transition count rep=3", ns, 4);
    chk(st_cyc[0] == 5, "R3 off time", st_cyc[0], 5);
    chk(st_cyc[1] == 8, "R3 on time", st_cyc[1], 8);
    chk(st_cyc[2] == 13, "R3 off time 2", st_cyc[2], 13);
    chk(st_cyc[3] == 16, "R3 on time 2", st_cyc[3], 16);
    chk(st_dat[0] == 8'hA5, "R1 data rise", int'(st_dat[0]), 'hA5);
    chk(st_dat[1] == 8'hA1, "R1 data fall", int'(st_dat[1]), 'hA1);
    chk(!active && remain == 0, "R5 idle after budget", int'(active), 0);
  endtask

  task automatic t_clamp();
    port_in = 8'h00;
    do_load(0, 0, 2, 7);
    chk(remain == 1, "R4 clamp off", int'(remain), 1);
    collect(10);
    chk(ns == 3, "R4 count", ns, 3);
    chk(st_cyc[0] == 1 && st_cyc[1] == 2 && st_cyc[2] == 3, "R4 spacing", st_cyc[2], 3);
    chk(st_dat[0] == 8'h80 && st_dat[1] == 8'h00, "R10 bit 7 lane", int'(st_dat[0]), 'h80);
    chk(bit_val, "R1 final level", int'(bit_val), 1);
  endtask

  task automatic t_restart();
    do_load(4, 20, 5, 7);
    chk(remain == 4, "R6 first interval from high level", int'(remain), 4);
    collect(6);
    chk(ns == 1 && st_cyc[0] == 4, "R6 first strobe", st_cyc[0], 4);
    do_load(2, 7, 0, 7);
    collect(25);
    chk(ns == 1, "R6 pending cancelled", ns, 1);
    chk(st_cyc[0] == 7, "R6 restart timing", st_cyc[0], 7);
  endtask

  task automatic t_merge();
    port_in = 8'h3C;
    do_load(2, 2, 1, 0);
    collect(2);
    port_in = 8'hC3;
    collect(6);
    chk(ns == 2, "R2 count", ns, 2);
    chk(st_dat[0] == 8'h3C, "R2 merge before change", int'(st_dat[0]), 'h3C);
    chk(st_dat[1] == 8'hC3, "R2 merge after change", int'(st_dat[1]), 'hC3);
  endtask

  task automatic t_clear();
    logic b;
    do_load(6, 6, 10, 1);
    collect(3);
    b = bit_val;
    cfg_clear = 1'b1;
    @(negedge clk);
    cfg_clear = 1'b0;
    t0 = cyc; ns = 0;
    chk(!active && remain == 0, "R7 clear idles", int'(remain), 0);
    collect(20);
    chk(ns == 0, "R7 no strobe after clear", ns, 0);
    chk(bit_val == b, "R7 level kept", int'(bit_val), int'(b));
  endtask

  task automatic t_reset_mid();
    do_load(8, 8, 10, 4);
    collect(3);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    t0 = cyc; ns = 0;
    t_reset();
    collect(20);
    chk(ns == 0, "R8 reset cancels", ns, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_clamp();
        t_restart();
        t_merge();
        t_clear();
        t_reset_mid();
      end
      begin
        repeat (20000) @(negedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule